// File: doc/BRIEF.md
# Unimplemented Coprocessor Instruction Trap Sequencer

This block sits next to an in-order integer core. It watches each decoded instruction word and traps any word in the floating-point opcode line that the coprocessor cannot run. A word traps if the coprocessor is switched off, or if it is switched on but the decoder has flagged the operation as unimplemented. On a trap the block stalls the core. It waits until earlier coprocessor work has drained and until any exception already pending has been serviced.

The block then snapshots the status register. It writes the live status register back with supervisor mode on and tracing off. It pushes a 12-byte frame to the stack-write port and moves the stack pointer down by that amount. It then reads the handler address from the vector table and redirects the fetch unit. The stall is released once the fetch unit reports that its pipeline has been refilled. Both trap causes use the same vector and the same frame. A separate cause output tells them apart.

Top module: `fline_trap_seq`

## Requirements
- R1: Only an instruction word whose bits [15:12] equal 4'hF can start a trap. Any other word is ignored: no stall, no stack write, no status write.
- R2: A line-F word traps with `cause_unimpl` when `fpu_en` is 1 and `insn_unimpl` is 1. It traps with `cause_disabled` when `fpu_en` is 0, whatever `insn_unimpl` is. With `fpu_en` 1 and `insn_unimpl` 0 it is ignored. At most one cause is high, and only while `stall` is high.
- R3: The status write does not happen until a clock edge at which both `fp_busy` and `exc_pending` are low.
- R4: The status write is the first side effect. `sr_wr_data` equals `sr_in` with bit 13 (supervisor) set and bit 15 (trace) cleared. The frame stores the unmodified `sr_in` seen at that moment.
- R5: After the frame, the vector table is read at `vbr_in + 0x2C`, which is vector 11 times 4.
- R6: Exactly four stack writes occur, in this order. With S the stack pointer minus 12: the effective address as a long at S+8; then the word 0x202C (format 2 in bits [15:12], offset 0x02C in [11:0]) at S+6; then the PC as a long at S+2; then the status copy as a word at S. `stk_wr_long` is 1 for a 32-bit write and 0 for a 16-bit write.
- R7: The stored PC is `insn_next_pc`, the address of the following instruction.
- R8: The effective-address field is `insn_ea` when `insn_mem` is 1 and zero otherwise.
- R9: The stack pointer is written once, with `sp_in - 12`.
- R10: `fetch_redirect` pulses for one cycle with `fetch_pc` equal to the fetched handler address. `stall` stays high until `fill_done` is seen. After that a new instruction is accepted.
- R11: `stall` rises in the cycle after a qualifying word is accepted and stays high through the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Decoded instruction word is present |
| insn_word | input | 16 | First instruction word |
| insn_unimpl | input | 1 | Decoder flag: operation not implemented |
| insn_mem | input | 1 | Instruction has a memory operand |
| insn_ea | input | 32 | Computed operand effective address |
| insn_next_pc | input | 32 | Address of the following instruction |
| fpu_en | input | 1 | Coprocessor enable bit from the control register |
| fp_busy | input | 1 | Earlier coprocessor instructions still executing |
| exc_pending | input | 1 | Another exception is pending or being serviced |
| sr_in | input | 16 | Live status register |
| sr_wr_en | output | 1 | Write live status register |
| sr_wr_data | output | 16 | New status register value |
| sp_in | input | 32 | Supervisor stack pointer |
| sp_wr_en | output | 1 | Write stack pointer |
| sp_wr_data | output | 32 | New stack pointer |
| stk_wr_en | output | 1 | Stack memory write strobe |
| stk_wr_addr | output | 32 | Stack write byte address |
| stk_wr_data | output | 32 | Stack write data, right-aligned for word writes |
| stk_wr_long | output | 1 | 1 = 32-bit write, 0 = 16-bit write |
| vbr_in | input | 32 | Vector table base |
| vec_rd_en | output | 1 | Vector table read request, held until valid |
| vec_rd_addr | output | 32 | Vector table read address |
| vec_rd_valid | input | 1 | Read data valid |
| vec_rd_data | input | 32 | Handler address |
| fetch_redirect | output | 1 | One-cycle redirect pulse to fetch |
| fetch_pc | output | 32 | Redirect target |
| fill_done | input | 1 | Fetch pipeline refilled |
| stall | output | 1 | Core stall |
| cause_unimpl | output | 1 | Trap cause: unimplemented operation |
| cause_disabled | output | 1 | Trap cause: coprocessor disabled |

## Verification
The bench holds `fp_busy` and `exc_pending` high for several cycles after the trap word. A design that skipped draining would write the status register too early. The bench compares the frame's status word against the live-register write. A design that stored the modified value, or that snapshot the register after setting supervisor mode, would show the trace bit missing from the frame. The bench checks each write's address, size and order, plus the stored PC against the next-instruction address. This catches a faulting-PC frame, a swapped field or an off-by-two offset. Words outside line F, implemented operations, and a trap with no memory operand cover the qualification logic and the zeroed address field.

// File: rtl/fline_trap_pkg.sv
// Shared types for the unimplemented coprocessor instruction trap sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package fline_trap_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_LATCH_SR,
        ST_PUSH_ADDR,
        ST_PUSH_FMT,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_FETCH_VEC,
        ST_REFILL
    } trap_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE,
        CAUSE_UNIMPL,
        CAUSE_DISABLED
    } trap_cause_t;

endpackage

// File: rtl/fline_trap_qual.sv
// Qualifier: decides whether the offered instruction word traps, and why.
// Assumes the decoder has already produced the unimplemented flag; this
// module only looks at the opcode line and the coprocessor enable.
module fline_trap_qual
    import fline_trap_pkg::*;
#(
    parameter int                OPW       = 16,
    parameter int                LINE_W    = 4,
    parameter logic [LINE_W-1:0] LINE_CODE = 4'hF
) (
    input  logic           insn_valid,
    input  logic [OPW-1:0] insn_word,
    input  logic           insn_unimpl,
    input  logic           fpu_en,
    output logic           take,
    output trap_cause_t    cause
);

    localparam int SHIFT = OPW - LINE_W;

    logic line_hit;

    // Classify the word: line match first, then disabled beats unimplemented.
    always_comb begin
        line_hit = ((insn_word >> SHIFT) == OPW'(LINE_CODE));
        cause    = CAUSE_NONE;
        if (insn_valid && line_hit) begin
            if (!fpu_en)          cause = CAUSE_DISABLED;
            else if (insn_unimpl) cause = CAUSE_UNIMPL;
        end
        take = (cause != CAUSE_NONE);
    end

endmodule

// File: rtl/fline_trap_ctrl.sv
// Control FSM: steps through drain, status snapshot, four frame pushes,
// vector fetch and pipeline refill. Also produces the one-cycle redirect
// pulse. Assumes take is only meaningful while idle.
module fline_trap_ctrl
    import fline_trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic        fp_busy,
    input  logic        exc_pending,
    input  logic        vec_rd_valid,
    input  logic        fill_done,
    output trap_state_t state,
    output logic        redirect
);

    trap_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:      if (take) nxt = ST_DRAIN;
            ST_DRAIN:     if (!fp_busy && !exc_pending) nxt = ST_LATCH_SR;
            ST_LATCH_SR:  nxt = ST_PUSH_ADDR;
            ST_PUSH_ADDR: nxt = ST_PUSH_FMT;
            ST_PUSH_FMT:  nxt = ST_PUSH_PC;
            ST_PUSH_PC:   nxt = ST_PUSH_SR;
            ST_PUSH_SR:   nxt = ST_FETCH_VEC;
            ST_FETCH_VEC: if (vec_rd_valid) nxt = ST_REFILL;
            ST_REFILL:    if (fill_done && !redirect) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // State register and redirect pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            redirect <= 1'b0;
        end else begin
            state    <= nxt;
            redirect <= (state == ST_FETCH_VEC) && vec_rd_valid;
        end
    end

endmodule

// File: rtl/fline_trap_frame.sv
// Frame writer: turns the push states into stack-write beats and the
// stack pointer update. The stack grows downward; the frame occupies
// SR word, PC long, format word, EA long from the lowest address up.
// Assumes sp_base is the stack pointer before the frame.
module fline_trap_frame
    import fline_trap_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SRW      = 16,
    parameter int VEC_NUM  = 11,
    parameter int FMT_CODE = 2
) (
    input  trap_state_t    state,
    input  logic [AW-1:0]  sp_base,
    input  logic [SRW-1:0] sr_copy,
    input  logic [AW-1:0]  next_pc,
    input  logic [AW-1:0]  ea,
    output logic           stk_wr_en,
    output logic [AW-1:0]  stk_wr_addr,
    output logic [AW-1:0]  stk_wr_data,
    output logic           stk_wr_long,
    output logic           sp_wr_en,
    output logic [AW-1:0]  sp_wr_data
);

    localparam int SR_BYTES    = SRW / 8;
    localparam int LONG_BYTES  = AW / 8;
    localparam int FMT_BYTES   = 2;
    localparam int OFS_SR      = 0;
    localparam int OFS_PC      = OFS_SR + SR_BYTES;
    localparam int OFS_FMT     = OFS_PC + LONG_BYTES;
    localparam int OFS_EA      = OFS_FMT + FMT_BYTES;
    localparam int FRAME_BYTES = OFS_EA + LONG_BYTES;
    localparam logic [15:0] FMT_WORD = {4'(FMT_CODE), 12'(VEC_NUM * 4)};

    logic [AW-1:0] frame_base;

    // Pick the beat for the current push state.
    always_comb begin
        frame_base  = sp_base - AW'(FRAME_BYTES);
        stk_wr_en   = 1'b1;
        stk_wr_addr = '0;
        stk_wr_data = '0;
        stk_wr_long = 1'b0;
        sp_wr_en    = 1'b0;
        sp_wr_data  = frame_base;
        case (state)
            ST_PUSH_ADDR: begin
                stk_wr_addr = frame_base + AW'(OFS_EA);
                stk_wr_data = ea;
                stk_wr_long = 1'b1;
            end
            ST_PUSH_FMT: begin
                stk_wr_addr = frame_base + AW'(OFS_FMT);
                stk_wr_data = AW'(FMT_WORD);
            end
            ST_PUSH_PC: begin
                stk_wr_addr = frame_base + AW'(OFS_PC);
                stk_wr_data = next_pc;
                stk_wr_long = 1'b1;
            end
            ST_PUSH_SR: begin
                stk_wr_addr = frame_base + AW'(OFS_SR);
                stk_wr_data = AW'(sr_copy);
                sp_wr_en    = 1'b1;
            end
            default: stk_wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/fline_trap_seq.sv
// Top: unimplemented coprocessor instruction trap sequencer.
// Captures the trapping instruction's context, snapshots and rewrites the
// status register, pushes the frame, reads the vector and redirects fetch.
// Assumes sp_in is the supervisor stack pointer and is stable once drained.
module fline_trap_seq
    import fline_trap_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SRW      = 16,
    parameter int OPW      = 16,
    parameter int VEC_NUM  = 11,
    parameter int FMT_CODE = 2,
    parameter int S_BIT    = 13,
    parameter int T_BIT    = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           insn_valid,
    input  logic [OPW-1:0] insn_word,
    input  logic           insn_unimpl,
    input  logic           insn_mem,
    input  logic [AW-1:0]  insn_ea,
    input  logic [AW-1:0]  insn_next_pc,
    input  logic           fpu_en,
    input  logic           fp_busy,
    input  logic           exc_pending,
    input  logic [SRW-1:0] sr_in,
    output logic           sr_wr_en,
    output logic [SRW-1:0] sr_wr_data,
    input  logic [AW-1:0]  sp_in,
    output logic           sp_wr_en,
    output logic [AW-1:0]  sp_wr_data,
    output logic           stk_wr_en,
    output logic [AW-1:0]  stk_wr_addr,
    output logic [AW-1:0]  stk_wr_data,
    output logic           stk_wr_long,
    input  logic [AW-1:0]  vbr_in,
    output logic           vec_rd_en,
    output logic [AW-1:0]  vec_rd_addr,
    input  logic           vec_rd_valid,
    input  logic [AW-1:0]  vec_rd_data,
    output logic           fetch_redirect,
    output logic [AW-1:0]  fetch_pc,
    input  logic           fill_done,
    output logic           stall,
    output logic           cause_unimpl,
    output logic           cause_disabled
);

    localparam int VEC_OFS = VEC_NUM * 4;

    trap_state_t    state;
    trap_cause_t    new_cause;
    trap_cause_t    cause_q;
    logic           take;
    logic [AW-1:0]  next_pc_q;
    logic [AW-1:0]  ea_q;
    logic [SRW-1:0] sr_copy_q;
    logic [AW-1:0]  sp_base_q;
    logic [AW-1:0]  handler_q;

    fline_trap_qual #(.OPW(OPW)) u_qual (
        .insn_valid  (insn_valid),
        .insn_word   (insn_word),
        .insn_unimpl (insn_unimpl),
        .fpu_en      (fpu_en),
        .take        (take),
        .cause       (new_cause)
    );

    fline_trap_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .fp_busy      (fp_busy),
        .exc_pending  (exc_pending),
        .vec_rd_valid (vec_rd_valid),
        .fill_done    (fill_done),
        .state        (state),
        .redirect     (fetch_redirect)
    );

    fline_trap_frame #(
        .AW(AW), .SRW(SRW), .VEC_NUM(VEC_NUM), .FMT_CODE(FMT_CODE)
    ) u_frame (
        .state       (state),
        .sp_base     (sp_base_q),
        .sr_copy     (sr_copy_q),
        .next_pc     (next_pc_q),
        .ea          (ea_q),
        .stk_wr_en   (stk_wr_en),
        .stk_wr_addr (stk_wr_addr),
        .stk_wr_data (stk_wr_data),
        .stk_wr_long (stk_wr_long),
        .sp_wr_en    (sp_wr_en),
        .sp_wr_data  (sp_wr_data)
    );

    // Capture instruction context on accept, status/stack at snapshot, handler on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q   <= CAUSE_NONE;
            next_pc_q <= '0;
            ea_q      <= '0;
            sr_copy_q <= '0;
            sp_base_q <= '0;
            handler_q <= '0;
        end else begin
            if (state == ST_IDLE && take) begin
                cause_q   <= new_cause;
                next_pc_q <= insn_next_pc;
                ea_q      <= insn_mem ? insn_ea : '0;
            end
            if (state == ST_LATCH_SR) begin
                sr_copy_q <= sr_in;
                sp_base_q <= sp_in;
            end
            if (state == ST_FETCH_VEC && vec_rd_valid)
                handler_q <= vec_rd_data;
        end
    end

    // Live status rewrite: supervisor on, trace off.
    always_comb begin
        sr_wr_en          = (state == ST_LATCH_SR);
        sr_wr_data        = sr_in;
        sr_wr_data[S_BIT] = 1'b1;
        sr_wr_data[T_BIT] = 1'b0;
    end

    // Vector read, redirect target, stall and cause reporting.
    always_comb begin
        vec_rd_en      = (state == ST_FETCH_VEC);
        vec_rd_addr    = vbr_in + AW'(VEC_OFS);
        fetch_pc       = handler_q;
        stall          = (state != ST_IDLE);
        cause_unimpl   = stall && (cause_q == CAUSE_UNIMPL);
        cause_disabled = stall && (cause_q == CAUSE_DISABLED);
    end

endmodule

// File: rtl/fline_trap_chk.sv
// Checker: temporal properties of the trap sequencer's ports.
// Assumes it is bound into fline_trap_seq; observes only.
module fline_trap_chk #(
    parameter int AW      = 32,
    parameter int SRW     = 16,
    parameter int VEC_NUM = 11,
    parameter int S_BIT   = 13,
    parameter int T_BIT   = 15
) (
    input logic           clk,
    input logic           rst_n,
    input logic           stall,
    input logic           fp_busy,
    input logic           exc_pending,
    input logic           sr_wr_en,
    input logic [SRW-1:0] sr_wr_data,
    input logic           stk_wr_en,
    input logic           sp_wr_en,
    input logic           vec_rd_en,
    input logic [AW-1:0]  vec_rd_addr,
    input logic [AW-1:0]  vbr_in,
    input logic           fetch_redirect,
    input logic           cause_unimpl,
    input logic           cause_disabled
);

    localparam logic [SRW-1:0] ST_MASK = (SRW'(1) << S_BIT) | (SRW'(1) << T_BIT);
    localparam logic [SRW-1:0] S_ONLY  = SRW'(1) << S_BIT;

    // R3: status rewrite only after a cycle with drain and no pending exception
    p_drain_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_wr_en) |-> $past(!fp_busy && !exc_pending));

    // R4: rewritten status has supervisor set and trace clear
    p_sr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_en |-> ((sr_wr_data & ST_MASK) == S_ONLY));

    // R6: frame pushes begin right after the status rewrite
    p_push_after_sr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_en |=> stk_wr_en);

    // R5: vector read follows the stack pointer update, at vector 11
    p_vec_after_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_en |=> vec_rd_en);
    p_vec_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd_en |-> (vec_rd_addr == vbr_in + AW'(VEC_NUM * 4)));

    // R11: stack writes only while stalled; stall holds after redirect
    p_wr_in_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_wr_en |-> stall);
    p_redirect_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_redirect |-> stall);

    // R2: causes exclusive and only during a trap
    p_cause_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cause_unimpl, cause_disabled}) && ((cause_unimpl || cause_disabled) -> stall));

endmodule

bind fline_trap_seq fline_trap_chk #(
    .AW(AW), .SRW(SRW), .VEC_NUM(VEC_NUM), .S_BIT(S_BIT), .T_BIT(T_BIT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stall          (stall),
    .fp_busy        (fp_busy),
    .exc_pending    (exc_pending),
    .sr_wr_en       (sr_wr_en),
    .sr_wr_data     (sr_wr_data),
    .stk_wr_en      (stk_wr_en),
    .sp_wr_en       (sp_wr_en),
    .vec_rd_en      (vec_rd_en),
    .vec_rd_addr    (vec_rd_addr),
    .vbr_in         (vbr_in),
    .fetch_redirect (fetch_redirect),
    .cause_unimpl   (cause_unimpl),
    .cause_disabled (cause_disabled)
);

// File: tb/fline_trap_seq_tb.sv
// Directed bench for fline_trap_seq: one task per scenario.
module fline_trap_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [15:0] insn_word = '0;
    logic        insn_unimpl = 1'b0;
    logic        insn_mem = 1'b0;
    logic [31:0] insn_ea = '0;
    logic [31:0] insn_next_pc = '0;
    logic        fpu_en = 1'b1;
    logic        fp_busy = 1'b0;
    logic        exc_pending = 1'b0;
    logic [15:0] sr_in = '0;
    logic        sr_wr_en;
    logic [15:0] sr_wr_data;
    logic [31:0] sp_in = '0;
    logic        sp_wr_en;
    logic [31:0] sp_wr_data;
    logic        stk_wr_en;
    logic [31:0] stk_wr_addr;
    logic [31:0] stk_wr_data;
    logic        stk_wr_long;
    logic [31:0] vbr_in = 32'h0000_0400;
    logic        vec_rd_en;
    logic [31:0] vec_rd_addr;
    logic        vec_rd_valid = 1'b0;
    logic [31:0] vec_rd_data = '0;
    logic        fetch_redirect;
    logic [31:0] fetch_pc;
    logic        fill_done = 1'b0;
    logic        stall;
    logic        cause_unimpl;
    logic        cause_disabled;

    localparam logic [31:0] HANDLER = 32'h0001_2340;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Logs gathered by the monitor.
    int          n_wr;
    logic [31:0] wr_addr [8];
    logic [31:0] wr_data [8];
    logic        wr_long [8];
    int          n_sr, sr_cyc, n_sp, n_redir, n_vec;
    logic [15:0] sr_val;
    logic [31:0] sp_val, redir_pc, vec_addr;
    logic        saw_unimpl, saw_disabled;
    int          fill_cnt;

    fline_trap_seq u_dut (.*);

    always #4 clk = ~clk;

    task automatic clear_logs();
        n_wr = 0; n_sr = 0; n_sp = 0; n_redir = 0; n_vec = 0; sr_cyc = 0;
        saw_unimpl = 1'b0; saw_disabled = 1'b0;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor and responders, all at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (stk_wr_en && n_wr < 8) begin
            wr_addr[n_wr] = stk_wr_addr;
            wr_data[n_wr] = stk_wr_data;
            wr_long[n_wr] = stk_wr_long;
            n_wr++;
        end
        if (sr_wr_en) begin n_sr++; sr_val = sr_wr_data; sr_cyc = cyc; end
        if (sp_wr_en) begin n_sp++; sp_val = sp_wr_data; end
        if (vec_rd_en) begin n_vec++; vec_addr = vec_rd_addr; end
        if (fetch_redirect) begin n_redir++; redir_pc = fetch_pc; fill_cnt = 3; end
        if (cause_unimpl) saw_unimpl = 1'b1;
        if (cause_disabled) saw_disabled = 1'b1;
        vec_rd_valid <= vec_rd_en && !vec_rd_valid;
        vec_rd_data  <= HANDLER;
        if (fill_cnt > 0) begin
            fill_cnt = fill_cnt - 1;
            fill_done <= (fill_cnt == 0);
        end else fill_done <= 1'b0;
    end

    task automatic offer(input logic [15:0] w, input logic un, input logic en,
                         input logic mem, input logic [31:0] ea, input logic [31:0] npc);
        @(posedge clk); #1;
        insn_valid = 1'b1; insn_word = w; insn_unimpl = un; fpu_en = en;
        insn_mem = mem; insn_ea = ea; insn_next_pc = npc;
        @(posedge clk); #1;
        insn_valid = 1'b0;
    endtask

    // Full trap scenario with drain delays; checks frame, SR, SP, vector, redirect.
    task automatic run_trap(input string name, input logic [15:0] w, input logic un,
                            input logic en, input logic mem, input logic [31:0] ea,
                            input logic [31:0] npc, input logic [31:0] sp,
                            input logic [15:0] sr, input int busy_n, input int pend_n,
                            input bit exp_disabled);
        int rel_cyc;
        int waited;
        logic [31:0] base;
        clear_logs();
        sp_in = sp; sr_in = sr;
        fp_busy = (busy_n > 0); exc_pending = (pend_n > 0);
        offer(w, un, en, mem, ea, npc);
        @(negedge clk);
        chk(stall === 1'b1, "R11", {name, " stall after accept"}, 32'(stall), 1);
        for (int i = 0; i < busy_n; i++) @(posedge clk);
        #1 fp_busy = 1'b0;
        for (int i = 0; i < pend_n; i++) @(posedge clk);
        #1 exc_pending = 1'b0;
        rel_cyc = cyc;
        waited = 0;
        while (stall !== 1'b0 && waited < 200) begin @(negedge clk); waited++; end
        base = sp - 32'd12;
        chk(sr_cyc > rel_cyc && n_sr == 1, "R3", {name, " SR write after drain"}, 32'(sr_cyc), 32'(rel_cyc + 1));
        chk(sr_val == ((sr | 16'h2000) & 16'h7FFF), "R4", {name, " live SR"}, 32'(sr_val), 32'((sr | 16'h2000) & 16'h7FFF));
        chk(n_wr == 4, "R6", {name, " write count"}, 32'(n_wr), 4);
        if (n_wr == 4) begin
            chk(wr_addr[0] == base + 8 && wr_long[0] == 1'b1, "R6", {name, " EA slot"}, wr_addr[0], base + 8);
            chk(wr_data[0] == (mem ? ea : 32'd0), "R8", {name, " EA value"}, wr_data[0], mem ? ea : 32'd0);
            chk(wr_addr[1] == base + 6 && wr_long[1] == 1'b0 && wr_data[1] == 32'h202C, "R6", {name, " format word"}, wr_data[1], 32'h202C);
            chk(wr_addr[2] == base + 2 && wr_long[2] == 1'b1, "R6", {name, " PC slot"}, wr_addr[2], base + 2);
            chk(wr_data[2] == npc, "R7", {name, " saved PC"}, wr_data[2], npc);
            chk(wr_addr[3] == base && wr_long[3] == 1'b0 && wr_data[3] == 32'(sr), "R4", {name, " frame SR copy"}, wr_data[3], 32'(sr));
        end
        chk(n_sp == 1 && sp_val == base, "R9", {name, " new SP"}, sp_val, base);
        chk(n_vec > 0 && vec_addr == vbr_in + 32'h2C, "R5", {name, " vector addr"}, vec_addr, vbr_in + 32'h2C);
        chk(n_redir == 1 && redir_pc == HANDLER, "R10", {name, " redirect"}, redir_pc, HANDLER);
        chk(stall === 1'b0, "R10", {name, " stall released"}, 32'(stall), 0);
        chk(saw_disabled == exp_disabled && saw_unimpl == !exp_disabled, "R2", {name, " cause"},
            32'({saw_unimpl, saw_disabled}), 32'({!exp_disabled, exp_disabled}));
    endtask

    // Word that must not trap: no stall and no side effect.
    task automatic run_ignore(input string name, input string req, input logic [15:0] w,
                              input logic un, input logic en);
        bit any_stall = 0;
        clear_logs();
        fp_busy = 1'b0; exc_pending = 1'b0;
        offer(w, un, en, 1'b1, 32'hDEAD_0000, 32'h100);
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (stall) any_stall = 1; end
        chk(!any_stall && n_wr == 0 && n_sr == 0, req, {name, " ignored"}, 32'(n_wr + n_sr + any_stall), 0);
    endtask

    task automatic run_reset();
        @(negedge clk);
        chk(stall === 1'b0 && stk_wr_en === 1'b0 && sr_wr_en === 1'b0 && vec_rd_en === 1'b0,
            "R11", "reset idle", 32'({stall, stk_wr_en, sr_wr_en, vec_rd_en}), 0);
        chk(fetch_redirect === 1'b0 && cause_unimpl === 1'b0 && cause_disabled === 1'b0,
            "R2", "reset outputs", 32'({fetch_redirect, cause_unimpl, cause_disabled}), 0);
    endtask

    bit finished = 0;

    initial begin
        fill_cnt = 0;
        clear_logs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        run_reset();
        run_trap("unimpl_mem", 16'hF200, 1, 1, 1, 32'h0000_8000, 32'h0000_2004,
                 32'h0000_1000, 16'h8704, 4, 3, 0);
        run_trap("disabled_nomem", 16'hF23C, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_300A,
                 32'h0000_2000, 16'h0010, 0, 0, 1);
        run_trap("disabled_unimpl", 16'hFFFF, 1, 0, 1, 32'h1234_5678, 32'h0000_4002,
                 32'h0000_0800, 16'hA71F, 2, 0, 1);
        run_ignore("other_line", "R1", 16'h4E71, 1, 1);
        run_ignore("implemented", "R2", 16'hF200, 0, 1);
        run_ignore("line_E", "R1", 16'hE200, 1, 0);
        run_trap("back_to_back", 16'hF000, 1, 1, 1, 32'h0000_0040, 32'h0000_5000,
                 32'h0000_1800, 16'h0000, 0, 5, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule